// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

The unit gathers seven interrupt sources into one active-low request line. Three sources (two timers and a shift register) arrive as single-cycle set pulses from blocks outside this unit. Four arrive as control-line levels (CA1, CA2, CB1, CB2), which are synchronised and edge-detected under the control of a peripheral control register. Each detected event latches a sticky flag. Software enables sources through a bit-7 set/clear write, and removes flags by writing ones.

A read port returns the selected register. A flag read shows, in bit 7, whether any enabled flag is pending. The `STRICT_CLR` parameter selects a second clear rule: a flag write then clears only when bit 7 of the written data is also 1.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset, all three registers read as zero (the enable register reads 0x80), and `irq_no` is 1.
- R2: A pulse on `t1_set_i`, `t2_set_i` or `sr_set_i` sets flag bit 6, 5 or 2 respectively in the cycle after the pulse is sampled.
- R3: CA1 sets flag bit 1 and CB1 sets flag bit 4. Each fires on a falling edge when its control bit (bit 0 for CA1, bit 4 for CB1) is 0, and on a rising edge when it is 1. The opposite edge sets nothing.
- R4: CA2 sets flag bit 0, under control bits 3:1. CB2 sets flag bit 3, under control bits 7:5. When the top bit of the field is 0, the line is an input. In that case the middle bit selects the edge (1 rising, 0 falling), and the low bit (independent mode) does not change flag behaviour. When the top bit is 1, the line never sets its flag.
- R5: A write to the flag register (select 1) clears every flag whose data bit in 6:0 is 1 and leaves the others unchanged.
- R6: With `STRICT_CLR` = 1, a flag write whose data bit 7 is 0 clears nothing. With `STRICT_CLR` = 0, data bit 7 has no effect on the clear.
- R7: A write to the enable register (select 2) with data bit 7 = 1 sets the enables named by bits 6:0. With bit 7 = 0, it clears them. Unnamed enables keep their value.
- R8: A read of the flag register returns, in bit 7, 1 exactly when some flag is set whose enable is also set. A read of the enable register returns 1 in bit 7.
- R9: `irq_no` is 0 exactly when some flag and its enable are both set.
- R10: When a flag is set by an event in the same cycle that a write clears it, the flag ends up set.
- R11: A flag stays set until it is cleared by a write. The control register (select 0) reads back the value last written to it.
- R12: A control-line change sampled at clock edge k sets its flag at edge k+2, and the flag is readable after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| t1_set_i | input | 1 | Timer 1 event pulse |
| t2_set_i | input | 1 | Timer 2 event pulse |
| sr_set_i | input | 1 | Shift register event pulse |
| ca1_i | input | 1 | Control line A1 |
| ca2_i | input | 1 | Control line A2 |
| cb1_i | input | 1 | Control line B1 |
| cb2_i | input | 1 | Control line B2 |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 control, 1 flags, 2 enables |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 2 | Read target, same encoding as `wr_sel_i` |
| rd_data_o | output | 8 | Selected register contents |
| irq_no | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach is a new event and a clearing write that land on the same flag in the same clock cycle. The bench creates it by driving a timer pulse and a flag write from one stimulus vector, so both are sampled at one edge.

Edge-polarity checks need the opposite edge to arrive first, because the lines idle high. Each control-register setting is therefore followed by a walk of both edges, with a read after each one. The strict-clear rule is compared against a second instance that receives the same stimulus.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  typedef enum logic [1:0] {
    SEL_PCR = 2'd0,
    SEL_IFR = 2'd1,
    SEL_IER = 2'd2
  } reg_sel_e;

  localparam int unsigned N_FLG   = 7;
  localparam int unsigned FLG_CA2 = 0;
  localparam int unsigned FLG_CA1 = 1;
  localparam int unsigned FLG_SR  = 2;
  localparam int unsigned FLG_CB2 = 3;
  localparam int unsigned FLG_CB1 = 4;
  localparam int unsigned FLG_T2  = 5;
  localparam int unsigned FLG_T1  = 6;
endpackage

// File: rtl/ifu_sync_edge.sv
module ifu_sync_edge #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= {(STAGES+1){RST_VAL}};
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  // sh_q[STAGES] is the previous synchronised value
  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/ifu_line_trig.sv
module ifu_line_trig (
  input  logic [3:0] ctl_i,
  input  logic       rise1_i,
  input  logic       fall1_i,
  input  logic       rise2_i,
  input  logic       fall2_i,
  output logic       trig1_o,
  output logic       trig2_o
);
  // ctl_i[0]: line-1 polarity; ctl_i[3:1]: line-2 mode, top bit = output mode
  assign trig1_o = ctl_i[0] ? rise1_i : fall1_i;
  assign trig2_o = ~ctl_i[3] & (ctl_i[2] ? rise2_i : fall2_i);
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import ifu_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          STRICT_CLR  = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          t1_set_i,
  input  logic          t2_set_i,
  input  logic          sr_set_i,
  input  logic          ca1_i,
  input  logic          ca2_i,
  input  logic          cb1_i,
  input  logic          cb2_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [1:0]    rd_sel_i,
  output logic [DW-1:0] rd_data_o,
  output logic          irq_no
);
  localparam int unsigned NL = 4;
  localparam int unsigned NP = NL / 2;

  logic [DW-1:0]    pcr_q;
  logic [N_FLG-1:0] ifr_q, ier_q, ifr_d, ier_d, set_v, clr_v;
  logic [NL-1:0]    line_v, rise_v, fall_v;
  logic [NP-1:0]    trig1_v, trig2_v;
  logic             any_act;

  // line order: A1, A2, B1, B2
  assign line_v = {cb2_i, cb1_i, ca2_i, ca1_i};

  for (genvar g = 0; g < NL; g++) begin : g_sync
    ifu_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (line_v[g]),
      .rise_o (rise_v[g]),
      .fall_o (fall_v[g])
    );
  end

  for (genvar p = 0; p < NP; p++) begin : g_port
    ifu_line_trig u_trig (
      .ctl_i   (pcr_q[4*p +: 4]),
      .rise1_i (rise_v[2*p]),
      .fall1_i (fall_v[2*p]),
      .rise2_i (rise_v[2*p+1]),
      .fall2_i (fall_v[2*p+1]),
      .trig1_o (trig1_v[p]),
      .trig2_o (trig2_v[p])
    );
  end

  always_comb begin
    set_v          = '0;
    set_v[FLG_CA1] = trig1_v[0];
    set_v[FLG_CA2] = trig2_v[0];
    set_v[FLG_CB1] = trig1_v[1];
    set_v[FLG_CB2] = trig2_v[1];
    set_v[FLG_T1]  = t1_set_i;
    set_v[FLG_T2]  = t2_set_i;
    set_v[FLG_SR]  = sr_set_i;
  end

  always_comb begin
    clr_v = '0;
    if (wr_en_i && reg_sel_e'(wr_sel_i) == SEL_IFR && (!STRICT_CLR || wr_data_i[DW-1]))
      clr_v = wr_data_i[N_FLG-1:0];
    ifr_d = (ifr_q & ~clr_v) | set_v;  // new event wins over clear
  end

  always_comb begin
    ier_d = ier_q;
    if (wr_en_i && reg_sel_e'(wr_sel_i) == SEL_IER) begin
      if (wr_data_i[DW-1]) ier_d = ier_q |  wr_data_i[N_FLG-1:0];
      else                 ier_d = ier_q & ~wr_data_i[N_FLG-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ifr_q <= '0;
      ier_q <= '0;
      pcr_q <= '0;
    end else begin
      ifr_q <= ifr_d;
      ier_q <= ier_d;
      if (wr_en_i && reg_sel_e'(wr_sel_i) == SEL_PCR) pcr_q <= wr_data_i;
    end
  end

  assign any_act = |(ifr_q & ier_q);
  assign irq_no  = ~any_act;

  always_comb begin
    unique case (reg_sel_e'(rd_sel_i))
      SEL_PCR: rd_data_o = pcr_q;
      SEL_IFR: rd_data_o = {any_act, ifr_q};
      SEL_IER: rd_data_o = {1'b1, ier_q};
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_flag_unit_chk.sv
module irq_flag_unit_chk #(
  parameter bit STRICT_CLR = 1'b0
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       t1_set_i,
  input logic       wr_en_i,
  input logic [1:0] wr_sel_i,
  input logic [7:0] wr_data_i,
  input logic [1:0] rd_sel_i,
  input logic [7:0] rd_data_o,
  input logic       irq_no,
  input logic [6:0] ifr_q,
  input logic [6:0] ier_q
);
  logic wr_ifr, wr_ier;
  assign wr_ifr = wr_en_i && wr_sel_i == 2'd1;
  assign wr_ier = wr_en_i && wr_sel_i == 2'd2;

  p_reset_idle_r1: assert property (@(posedge clk_i) !rst_ni |-> irq_no);

  p_t1_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t1_set_i |=> ifr_q[6]);

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ifr && wr_data_i[6] && (!STRICT_CLR || wr_data_i[7]) && !t1_set_i |=> !ifr_q[6]);

  p_strict_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    STRICT_CLR && wr_ifr && !wr_data_i[7] && ifr_q[6] |=> ifr_q[6]);

  p_ier_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ier && wr_data_i[7] && wr_data_i[0] |=> ier_q[0]);

  p_ier_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ier && !wr_data_i[7] && wr_data_i[0] |=> !ier_q[0]);

  p_summary_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel_i == 2'd1 |-> rd_data_o[7] == !irq_no);

  p_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t1_set_i && ier_q[6] && !(wr_ier && !wr_data_i[7] && wr_data_i[6]) |=> !irq_no);

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t1_set_i && wr_ifr && wr_data_i[6] |=> ifr_q[6]);

  p_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ifr_q[6] && !wr_ifr |=> ifr_q[6]);
endmodule

bind irq_flag_unit irq_flag_unit_chk #(.STRICT_CLR(STRICT_CLR)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .t1_set_i  (t1_set_i),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .rd_sel_i  (rd_sel_i),
  .rd_data_o (rd_data_o),
  .irq_no    (irq_no),
  .ifr_q     (ifr_q),
  .ier_q     (ier_q)
);

// File: tb/irq_flag_unit_tb_top.sv
module irq_flag_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic t1 = 0, t2 = 0, sr = 0;
  logic ca1 = 1, ca2 = 1, cb1 = 1, cb2 = 1;
  logic we = 0;
  logic [1:0] wsel = 0, rsel = 0;
  logic [7:0] wdat = 0;
  logic [7:0] rd, rd_s;
  logic irq_n, irq_n_s;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_flag_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .t1_set_i(t1), .t2_set_i(t2), .sr_set_i(sr),
    .ca1_i(ca1), .ca2_i(ca2), .cb1_i(cb1), .cb2_i(cb2),
    .wr_en_i(we), .wr_sel_i(wsel), .wr_data_i(wdat),
    .rd_sel_i(rsel), .rd_data_o(rd), .irq_no(irq_n));

  irq_flag_unit #(.STRICT_CLR(1'b1)) dut_strict_i (
    .clk_i(clk), .rst_ni(rst_n), .t1_set_i(t1), .t2_set_i(t2), .sr_set_i(sr),
    .ca1_i(ca1), .ca2_i(ca2), .cb1_i(cb1), .cb2_i(cb2),
    .wr_en_i(we), .wr_sel_i(wsel), .wr_data_i(wdat),
    .rd_sel_i(rsel), .rd_data_o(rd_s), .irq_no(irq_n_s));

  // {t1,t2,sr, we, wsel[2], wdat[8], rsel[2], exp_rd[8], exp_irq_n}
  localparam int NV = 15;
  localparam logic [24:0] VEC [NV] = '{
    {3'b100, 1'b0, 2'd0, 8'h00, 2'd1, 8'h40, 1'b1},  // R2 t1 -> bit6
    {3'b000, 1'b1, 2'd2, 8'hC0, 2'd1, 8'hC0, 1'b0},  // R7 R8 R9
    {3'b000, 1'b0, 2'd0, 8'h00, 2'd2, 8'hC0, 1'b0},  // R8 IER bit7
    {3'b000, 1'b1, 2'd1, 8'h00, 2'd1, 8'hC0, 1'b0},  // R5 zero write
    {3'b000, 1'b1, 2'd1, 8'h40, 2'd1, 8'h00, 1'b1},  // R5 clear
    {3'b011, 1'b0, 2'd0, 8'h00, 2'd1, 8'h24, 1'b1},  // R2 t2, sr
    {3'b000, 1'b1, 2'd2, 8'hA0, 2'd2, 8'hE0, 1'b0},  // R7 set bit5
    {3'b000, 1'b0, 2'd0, 8'h00, 2'd1, 8'hA4, 1'b0},  // R8 R11
    {3'b000, 1'b1, 2'd2, 8'h20, 2'd2, 8'hC0, 1'b1},  // R7 clear bit5
    {3'b000, 1'b0, 2'd0, 8'h00, 2'd1, 8'h24, 1'b1},  // R11 sticky
    {3'b000, 1'b1, 2'd1, 8'h7F, 2'd1, 8'h00, 1'b1},  // R5 clear all
    {3'b100, 1'b1, 2'd1, 8'h40, 2'd1, 8'hC0, 1'b0},  // R10 set wins
    {3'b000, 1'b1, 2'd2, 8'h7F, 2'd2, 8'h80, 1'b1},  // R7 clear all
    {3'b000, 1'b1, 2'd0, 8'h66, 2'd0, 8'h66, 1'b1},  // R11 PCR
    {3'b000, 1'b1, 2'd1, 8'h7F, 2'd1, 8'h00, 1'b1}   // R5
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [2:0] p, input logic w, input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    {t1, t2, sr} = p; we = w; wsel = s; wdat = d;
    @(negedge clk);
    {t1, t2, sr} = 3'b000; we = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] s, input logic [7:0] exp);
    rsel = s; #1;
    chk(tag, rd, exp);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rd_chk("R1 pcr", 2'd0, 8'h00);
    rd_chk("R1 ifr", 2'd1, 8'h00);
    rd_chk("R1 ier", 2'd2, 8'h80);
    chk("R1 irq", {7'd0, irq_n}, 8'h01);
    rst_n = 1'b1;
    settle();
    rd_chk("R1 ifr after release", 2'd1, 8'h00);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][24:22], VEC[i][21], VEC[i][20:19], VEC[i][18:11]);
      rd_chk($sformatf("vec %0d (see table tag)", i), VEC[i][10:9], VEC[i][8:1]);
      chk($sformatf("R9 irq vec %0d", i), {7'd0, irq_n}, {7'd0, VEC[i][0]});
    end

    // R12 latency: change sampled at edge k, flag at edge k+2
    @(negedge clk); ca1 = 0;
    @(negedge clk); rsel = 2'd1; #1; chk("R12 not yet k", rd, 8'h00);
    @(negedge clk); #1; chk("R12 not yet k+1", rd, 8'h00);
    @(negedge clk); #1; chk("R12 set at k+2", rd, 8'h02);
    step(3'b000, 1, 2'd1, 8'h7F);
    ca1 = 1; settle(); rd_chk("R3 CA1 rise ignored", 2'd1, 8'h00);
    ca2 = 0; settle(); rd_chk("R4 CA2 fall ignored pos mode", 2'd1, 8'h00);
    ca2 = 1; settle(); rd_chk("R4 CA2 rise", 2'd1, 8'h01);
    cb2 = 0; settle(); rd_chk("R4 CB2 fall ignored", 2'd1, 8'h01);
    cb2 = 1; settle(); rd_chk("R4 CB2 rise", 2'd1, 8'h09);
    cb1 = 0; settle(); rd_chk("R3 CB1 fall", 2'd1, 8'h19);
    step(3'b000, 1, 2'd1, 8'h7F);
    cb1 = 1; settle(); rd_chk("R3 CB1 rise ignored", 2'd1, 8'h00);

    step(3'b000, 1, 2'd0, 8'h11);
    ca1 = 0; settle(); rd_chk("R3 CA1 fall ignored pos", 2'd1, 8'h00);
    ca1 = 1; settle(); rd_chk("R3 CA1 rise pos", 2'd1, 8'h02);
    cb1 = 0; settle(); rd_chk("R3 CB1 fall ignored pos", 2'd1, 8'h02);
    cb1 = 1; settle(); rd_chk("R3 CB1 rise pos", 2'd1, 8'h12);
    ca2 = 0; settle(); rd_chk("R4 CA2 fall mode 000", 2'd1, 8'h13);
    step(3'b000, 1, 2'd1, 8'h7F);
    ca2 = 1; settle(); rd_chk("R4 CA2 rise ignored neg", 2'd1, 8'h00);

    step(3'b000, 1, 2'd0, 8'h88);
    ca2 = 0; cb2 = 0; settle(); rd_chk("R4 output mode no flag", 2'd1, 8'h00);
    ca2 = 1; cb2 = 1; settle(); rd_chk("R4 output mode no flag rise", 2'd1, 8'h00);

    // R6 strict clear
    step(3'b000, 1, 2'd1, 8'hFF);
    step(3'b100, 0, 2'd0, 8'h00);
    step(3'b000, 1, 2'd1, 8'h40);
    rsel = 2'd1; #1;
    chk("R6 strict keeps flag", rd_s, 8'h40);
    chk("R6 normal ignores bit7", rd, 8'h00);
    step(3'b000, 1, 2'd1, 8'hC0);
    rsel = 2'd1; #1;
    chk("R6 strict clears with bit7", rd_s, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule